// File: doc/BRIEF.md
# Adder-Compare Unit with Carry and Zero Flags

This block is the arithmetic slice of a small RISC core. It adds or subtracts two operands of a parameterised width, and it keeps two architectural condition flags, Carry and Zero, in its own registers rather than in the register file. Each cycle the core presents two operands, an operation code and a write-back enable. The unit returns the result and a register write-enable at once, without a clock edge. At the next rising clock edge it updates whichever flags that operation is allowed to change.

The unsigned compare and the signed compare run the subtractor but never request a register write. Only the flags record their outcome, so comparing two values costs no temporary register. For a signed compare, the sign bit of each operand is inverted before the unsigned subtract, and one subtractor then serves both compares. Zero is found by testing the two raw operands for bitwise equality. This test runs beside the carry chain, not after it, so it adds no depth to the adder path.

Top module: `addcmp_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, `carry_flag` and `zero_flag` read 0 until an operation changes them.
- R2: Op code 1 (ADD) drives `result` = A+B mod 2^W and `reg_we` = `wb_en`. When `wb_en` is high, Carry takes the true carry-out of A+B at the next edge.
- R3: Op code 2 (SUB) drives `result` = A-B mod 2^W and `reg_we` = `wb_en`. When `wb_en` is high, Carry becomes 1 exactly when A >= B as unsigned numbers.
- R4: Op code 3 (CMPU) always holds `reg_we` at 0. When `wb_en` is high, Carry becomes 1 exactly when A >= B as unsigned numbers.
- R5: Op code 4 (CMPS) always holds `reg_we` at 0. When `wb_en` is high, Carry becomes 1 exactly when A >= B as two's-complement signed numbers.
- R6: When `wb_en` is high with op code 3 or 4, Zero becomes 1 at the next edge if A equals B, and 0 otherwise.
- R7: ADD and SUB never change Zero.
- R8: Op code 0 (MOV) drives `result` = B and `reg_we` = `wb_en`, and it changes neither flag. Codes 5 to 7 behave exactly like op code 0.
- R9: With `wb_en` low, `reg_we` is 0 and neither flag changes, whatever the op code.
- R10: ADD of a register holding 0 or 1 with the all-ones value leaves Carry equal to that register's value.
- R11: `result` and `reg_we` follow the inputs in the same cycle. The flags take their new value at the rising edge that ends the cycle of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | DATA_W | First operand (A) |
| op_b | input | DATA_W | Second operand (B) |
| op_sel | input | 3 | Operation code: 0 MOV, 1 ADD, 2 SUB, 3 CMPU, 4 CMPS, 5-7 as MOV |
| wb_en | input | 1 | Write-back enable for this operation |
| result | output | DATA_W | Combinational result |
| reg_we | output | 1 | Register write request |
| carry_flag | output | 1 | Current Carry flag |
| zero_flag | output | 1 | Current Zero flag |

## Verification
The bench aims at the points where the two compares part ways. Operand pairs that differ only in the sign bit, the most negative value against zero, and all-ones against zero expose a design that inverts the wrong bit or uses the wrong Carry polarity: such a design reports the opposite ordering. Equal operands, and an ADD between a compare and the flag read, catch a design whose Zero follows the sum or is changed by ADD and SUB. The ADD of 0 or 1 with the all-ones value catches a Carry that is not the true adder carry-out. A MOV or a disabled write-back placed between flag reads shows whether those operations leave the flags untouched.

// File: rtl/acu_pkg.sv
package acu_pkg;
   typedef enum logic [2:0] {
      ACU_MOV  = 3'd0,
      ACU_ADD  = 3'd1,
      ACU_SUB  = 3'd2,
      ACU_CMPU = 3'd3,
      ACU_CMPS = 3'd4
   } acu_op_e;

   function automatic logic op_is_cmp(input logic [2:0] op);
      return (op == ACU_CMPU) || (op == ACU_CMPS);
   endfunction

   function automatic logic op_is_arith(input logic [2:0] op);
      return (op == ACU_ADD) || (op == ACU_SUB) || op_is_cmp(op);
   endfunction

   function automatic logic op_is_subtract(input logic [2:0] op);
      return (op == ACU_SUB) || op_is_cmp(op);
   endfunction
endpackage

// File: rtl/acu_operand_prep.sv
module acu_operand_prep
   import acu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic [2:0]        op,
   output logic [DATA_W-1:0] x_out,
   output logic [DATA_W-1:0] y_out,
   output logic              cin
);
   localparam int MSB = DATA_W - 1;

   logic              flip_sign;
   logic              negate_b;
   logic [DATA_W-1:0] a_adj;
   logic [DATA_W-1:0] b_adj;

   // a signed compare moves both operands up by 2^(W-1)
   assign flip_sign = (op == ACU_CMPS);
   assign negate_b  = op_is_subtract(op);

   always_comb begin
      a_adj = a_in;
      b_adj = b_in;
      if (flip_sign) begin
         a_adj[MSB] = ~a_in[MSB];
         b_adj[MSB] = ~b_in[MSB];
      end
   end

   assign x_out = a_adj;
   assign y_out = negate_b ? ~b_adj : b_adj;
   assign cin   = negate_b;
endmodule

// File: rtl/acu_adder.sv
module acu_adder #(
   parameter int DATA_W = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout
);
   generate
      if (RIPPLE) begin : g_ripple
         logic [DATA_W:0] c;
         assign c[0] = cin;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]  = x[i] ^ y[i] ^ c[i];
            assign c[i+1]  = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
         end
         assign cout = c[DATA_W];
      end else begin : g_infer
         logic [DATA_W:0] wide;
         assign wide = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
         assign sum  = wide[DATA_W-1:0];
         assign cout = wide[DATA_W];
      end
   endgenerate
endmodule

// File: rtl/acu_eq_detect.sv
module acu_eq_detect #(
   parameter int DATA_W = 32,
   parameter int GROUP  = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic              equal
);
   localparam int NGRP  = (DATA_W + GROUP - 1) / GROUP;
   localparam int PAD_W = NGRP * GROUP;

   logic [PAD_W-1:0] same;
   logic [NGRP-1:0]  grp_ok;

   generate
      if (PAD_W > DATA_W) begin : g_pad
         assign same = {{(PAD_W-DATA_W){1'b1}}, a ~^ b};
      end else begin : g_nopad
         assign same = a ~^ b;
      end
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         assign grp_ok[g] = &same[g*GROUP +: GROUP];
      end
   endgenerate

   assign equal = &grp_ok;
endmodule

// File: rtl/acu_flags.sv
module acu_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic upd_carry,
   input  logic upd_zero,
   input  logic carry_nx,
   input  logic zero_nx,
   output logic carry_q,
   output logic zero_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q <= 1'b0;
         zero_q  <= 1'b0;
      end else begin
         if (upd_carry) carry_q <= carry_nx;
         if (upd_zero)  zero_q  <= zero_nx;
      end
   end

   AST_CARRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_carry |=> $stable(carry_q)); // R9
   AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_zero |=> $stable(zero_q)); // R7
endmodule

// File: rtl/addcmp_unit.sv
module addcmp_unit
   import acu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit RIPPLE   = 1'b0,
   parameter int EQ_GROUP = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [2:0]        op_sel,
   input  logic              wb_en,
   output logic [DATA_W-1:0] result,
   output logic              reg_we,
   output logic              carry_flag,
   output logic              zero_flag
);
   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("addcmp_unit: DATA_W must be at least 4");
      end
      if (EQ_GROUP < 1) begin : g_bad_group
         $error("addcmp_unit: EQ_GROUP must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] x_opnd, y_opnd, sum;
   logic              cin, cout, equal;
   logic              arith, cmp;

   assign arith = op_is_arith(op_sel);
   assign cmp   = op_is_cmp(op_sel);

   acu_operand_prep #(.DATA_W(DATA_W)) u_prep (
      .a_in(op_a), .b_in(op_b), .op(op_sel),
      .x_out(x_opnd), .y_out(y_opnd), .cin(cin)
   );

   acu_adder #(.DATA_W(DATA_W), .RIPPLE(RIPPLE)) u_add (
      .x(x_opnd), .y(y_opnd), .cin(cin), .sum(sum), .cout(cout)
   );

   // equality runs on raw operands, in parallel with the carry chain
   acu_eq_detect #(.DATA_W(DATA_W), .GROUP(EQ_GROUP)) u_eq (
      .a(op_a), .b(op_b), .equal(equal)
   );

   acu_flags u_flags (
      .clk(clk), .rst_n(rst_n),
      .upd_carry(wb_en & arith), .upd_zero(wb_en & cmp),
      .carry_nx(cout), .zero_nx(equal),
      .carry_q(carry_flag), .zero_q(zero_flag)
   );

   assign result = arith ? sum : op_b;
   assign reg_we = wb_en & ~cmp;

   AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cmp |-> !reg_we); // R4
   AST_CMPU_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && op_sel == ACU_CMPU) |=> carry_flag == $past(op_a >= op_b)); // R4
   AST_CMPS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && op_sel == ACU_CMPS) |=>
         carry_flag == $past($signed(op_a) >= $signed(op_b))); // R5
   AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && cmp) |=> zero_flag == $past(op_a == op_b)); // R6
   AST_ADDSUB_KEEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == ACU_ADD || op_sel == ACU_SUB) |=> $stable(zero_flag)); // R7
   AST_MOV_KEEP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      !arith |=> $stable(carry_flag)); // R8
   AST_NOWB_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_en |-> !reg_we); // R9
endmodule

// File: tb/addcmp_unit_test.sv
module addcmp_unit_test;
   localparam int W = 32;
   localparam logic [W-1:0] ONES = '1;
   localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] op_a = '0, op_b = '0;
   logic [2:0]   op_sel = 3'd0;
   logic         wb_en = 1'b0;
   logic [W-1:0] result;
   logic         reg_we, carry_flag, zero_flag;

   int total = 0, bad = 0;
   logic mc = 1'b0, mz = 1'b0;

   always #4 clk = ~clk;

   addcmp_unit #(.DATA_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
      .wb_en(wb_en), .result(result), .reg_we(reg_we),
      .carry_flag(carry_flag), .zero_flag(zero_flag)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // drive one operation, check outputs in-cycle, then the flags after the edge
   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [2:0] op, input logic wb, input string tag);
      logic [W:0]   wide;
      logic [W-1:0] er;
      logic         ewe, arith, cmp, nc;
      @(negedge clk);
      op_a = a; op_b = b; op_sel = op; wb_en = wb;
      cmp   = (op == 3'd3) || (op == 3'd4);
      arith = (op == 3'd1) || (op == 3'd2) || cmp;
      case (op)
         3'd1: begin wide = {1'b0, a} + {1'b0, b}; nc = wide[W]; er = wide[W-1:0]; end
         3'd2: begin er = a - b; nc = (a >= b); end
         3'd3: begin er = a - b; nc = (a >= b); end
         3'd4: begin er = a - b; nc = ($signed(a) >= $signed(b)); end
         default: begin er = b; nc = mc; end
      endcase
      ewe = wb && !cmp;
      #1;
      if (!cmp) chk(result === er, tag, "result", result, er);
      chk(reg_we === ewe, tag, "reg_we", {{(W-1){1'b0}}, reg_we}, {{(W-1){1'b0}}, ewe});
      if (wb && arith) mc = nc;
      if (wb && cmp)   mz = (a == b);
      @(posedge clk); #1;
      chk(carry_flag === mc, tag, "carry", {{(W-1){1'b0}}, carry_flag}, {{(W-1){1'b0}}, mc});
      chk(zero_flag === mz, tag, "zero", {{(W-1){1'b0}}, zero_flag}, {{(W-1){1'b0}}, mz});
   endtask

   task automatic t_reset();
      #1;
      chk(carry_flag === 1'b0 && zero_flag === 1'b0, "R1", "flags in reset",
          {30'd0, carry_flag, zero_flag}, '0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk(carry_flag === 1'b0 && zero_flag === 1'b0, "R1", "flags after reset",
          {30'd0, carry_flag, zero_flag}, '0);
   endtask

   task automatic t_add();
      apply(32'd5, 32'd7, 3'd1, 1'b1, "R2");
      apply(ONES, 32'd1, 3'd1, 1'b1, "R2");
      apply(MAXP, 32'd1, 3'd1, 1'b1, "R2");
      apply(MINN, MINN, 3'd1, 1'b1, "R2");
   endtask

   task automatic t_sub();
      apply(32'd9, 32'd9, 3'd2, 1'b1, "R3");
      apply(32'd3, 32'd9, 3'd2, 1'b1, "R3");
      apply(32'd0, ONES, 3'd2, 1'b1, "R3");
   endtask

   task automatic t_cmpu();
      apply(32'd42, 32'd42, 3'd3, 1'b1, "R4");
      apply(32'd1, 32'd2, 3'd3, 1'b1, "R4");
      apply(ONES, 32'd0, 3'd3, 1'b1, "R4");
      apply(MINN, MAXP, 3'd3, 1'b1, "R4");
   endtask

   task automatic t_cmps();
      apply(ONES, 32'd0, 3'd4, 1'b1, "R5");
      apply(MINN, 32'd0, 3'd4, 1'b1, "R5");
      apply(MAXP, MINN, 3'd4, 1'b1, "R5");
      apply(MINN, MINN, 3'd4, 1'b1, "R6");
      apply(32'd0, MINN, 3'd4, 1'b1, "R6");
   endtask

   task automatic t_zero_keep();
      apply(32'd8, 32'd8, 3'd3, 1'b1, "R6");
      apply(32'd1, 32'd2, 3'd1, 1'b1, "R7");
      apply(32'd4, 32'd3, 3'd2, 1'b1, "R7");
      apply(32'd8, 32'd9, 3'd3, 1'b1, "R6");
      apply(32'd7, 32'd7, 3'd2, 1'b1, "R7");
   endtask

   task automatic t_mov();
      apply(ONES, 32'd0, 3'd3, 1'b1, "R8");
      apply(32'd0, 32'h1234_5678, 3'd0, 1'b1, "R8");
      apply(32'd1, ONES, 3'd5, 1'b1, "R8");
      apply(32'd1, 32'd0, 3'd7, 1'b0, "R8");
   endtask

   task automatic t_nowb();
      apply(32'd3, 32'd3, 3'd3, 1'b1, "R9");
      apply(32'd1, 32'd2, 3'd3, 1'b0, "R9");
      apply(ONES, ONES, 3'd1, 1'b0, "R9");
      apply(32'd0, 32'd5, 3'd0, 1'b0, "R9");
   endtask

   task automatic t_restore();
      apply(32'd1, ONES, 3'd1, 1'b1, "R10");
      chk(carry_flag === 1'b1, "R10", "carry restored from 1", {31'd0, carry_flag}, 32'd1);
      apply(32'd0, ONES, 3'd1, 1'b1, "R10");
      chk(carry_flag === 1'b0, "R10", "carry restored from 0", {31'd0, carry_flag}, 32'd0);
   endtask

   task automatic t_timing();
      apply(32'd2, 32'd1, 3'd3, 1'b1, "R11");
      @(negedge clk);
      op_a = 32'd1; op_b = 32'd2; op_sel = 3'd3; wb_en = 1'b1;
      #1;
      chk(carry_flag === 1'b1, "R11", "carry before edge", {31'd0, carry_flag}, 32'd1);
      mc = 1'b0; mz = 1'b0;
      @(posedge clk); #1;
      chk(carry_flag === 1'b0, "R11", "carry after edge", {31'd0, carry_flag}, 32'd0);
   endtask

   task automatic t_random();
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] a, b;
         a = $urandom;
         b = (i % 5 == 0) ? a : $urandom;
         apply(a, b, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R2/R3/R4/R5/R6 random");
      end
   endtask

   bit finished = 1'b0;

   initial begin
      #(8 * 200000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_add();
      t_sub();
      t_cmpu();
      t_cmps();
      t_zero_keep();
      t_mov();
      t_nowb();
      t_restore();
      t_timing();
      t_random();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule